// File: doc/BRIEF.md
# PCI Host Bridge Register Block

This block is the CPU-facing register file of a PCI host bridge. A CPU reaches it over a simple 32-bit register bus with a request/ready handshake. The low 256 bytes of its window are the bridge's own configuration header, held locally. Above that window sit three control registers: a configuration target address, a memory base and an I/O base. A data port turns each CPU access into one 4-byte configuration cycle on a downstream request/acknowledge port, aimed at the stored target address.

The bridge stalls the CPU by holding ready low until the downstream side acknowledges. The I/O base register also supplies the base of a 256 KB I/O window to an external address translator. A small router takes interrupt level updates tagged with a device/function number and forwards each one to one of four interrupt outputs, chosen by the device's slot.

Top module: `pci_hb_regs`

## Requirements
- R1: Only accesses with all four byte enables set (`be_i` = 4'hF) take effect. Any other access completes at once with ready high and read data 0. It changes no register and starts no downstream cycle.
- R2: Word offsets 0x000 to 0x0FC are 64 words of local configuration storage, readable and writable as full 32-bit words. Ready is returned in the same cycle.
- R3: After reset, word 0x000 reads {DEVICE_ID, VENDOR_ID} (device ID in bits 31:16) and word 0x004 reads 0x0290_0080. That value is command bit 7 (wait-cycle control), plus status bits 4, 7 and 9 (capabilities list, fast back-to-back, medium device-select timing) in bits 31:16. Every other local word reads 0.
- R4: Writes to word 0x000 (vendor and device identifiers) are ignored.
- R5: Offset 0x1C0 is the configuration address register. It stores and returns all 32 bits.
- R6: Offset 0x1C4 is the memory base register. It keeps only the bits under mask 0xFF00_0001, and every other bit reads 0.
- R7: Offset 0x1C8 is the I/O base register. It keeps only the bits under mask 0xFFFC_0001. `io_win_base_o` equals the register ANDed with 0xFFFC_0000, and it changes on the clock edge that takes the write.
- R8: A full-width write to offset 0x220 raises `cfg_req_o` in the next cycle, with `cfg_we_o`=1, `cfg_addr_o` equal to the configuration address register and `cfg_wdata_o` equal to the written data. Ready stays low until the cycle in which `cfg_ack_i` is high. With an acknowledge D cycles after the request appears, the CPU sees exactly D+1 cycles with ready low.
- R9: A full-width read of offset 0x220 starts a downstream cycle with `cfg_we_o`=0. It returns `cfg_rdata_i` as the read data in the acknowledge cycle.
- R10: Reads of any offset in the 10-bit window that is not one of the above return 0. Writes there change nothing.
- R11: An interrupt update (`irq_upd_i`) carrying device/function number F sets `irq_o[F[7:3]]` to `irq_level_i` on the next edge when F[7:3] < 4. Updates from higher slots leave all outputs unchanged.
- R12: After reset, the three control registers, `io_win_base_o` and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register-bus request, held until ready |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Byte offset in the register window |
| be_i | input | 4 | Byte enables |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid when ready |
| ready_o | output | 1 | Access completes this cycle |
| cfg_req_o | output | 1 | Downstream configuration cycle request |
| cfg_we_o | output | 1 | Downstream cycle is a write |
| cfg_addr_o | output | 32 | Downstream configuration address |
| cfg_wdata_o | output | 32 | Downstream write data |
| cfg_rdata_i | input | 32 | Downstream read data |
| cfg_ack_i | input | 1 | Downstream cycle done |
| io_win_base_o | output | 32 | Base of the 256 KB I/O window |
| irq_upd_i | input | 1 | Interrupt level update strobe |
| irq_devfn_i | input | 8 | Device/function number of the update |
| irq_level_i | input | 1 | New interrupt level |
| irq_o | output | 4 | Interrupt outputs, one per slot |

## Verification
The bench sweeps every local word and every unmapped word offset, then rereads all state. A decoder that aliased the unmapped range onto the local words, or that let the identifier word be written, would show up as a changed word. The base registers are checked against several data patterns, so a wrong mask leaks stray bits into the readback or into the I/O window output. Data-port accesses run with several acknowledge delays, and the stall length is checked exactly, so a bridge that released the CPU early or late fails. All 256 device/function numbers are sent through the router, which would catch a slot taken from the function bits or an out-of-range slot that wrapped onto a real line.

// File: rtl/pci_hb_pkg.sv
package pci_hb_pkg;
  localparam int          CFG_WORDS = 64;
  localparam int          OFF_PAR   = 'h1C0;
  localparam int          OFF_MBR   = 'h1C4;
  localparam int          OFF_IOBR  = 'h1C8;
  localparam int          OFF_DPORT = 'h220;
  localparam logic [31:0] MBR_MASK  = 32'hFF00_0001;
  localparam logic [31:0] IOBR_MASK = 32'hFFFC_0001;
  localparam logic [31:0] WIN_MASK  = 32'hFFFC_0000;
  // status: cap list | fast b2b | devsel medium ; command: wait cycle ctrl
  localparam logic [31:0] CMD_STAT_RST = 32'h0290_0080;

  typedef enum logic [1:0] {SEL_NONE, SEL_PAR, SEL_MBR, SEL_IOBR} ctrl_sel_e;
endpackage

// File: rtl/pci_hb_cfgspace.sv
module pci_hb_cfgspace #(
  parameter int          WORDS     = 64,
  parameter logic [15:0] VENDOR_ID = 16'h1AB5,
  parameter logic [15:0] DEVICE_ID = 16'h0A11,
  localparam int         IW        = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [IW-1:0] idx_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  import pci_hb_pkg::*;

  logic [31:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
      mem_q[1] <= CMD_STAT_RST;
    end else if (wr_i && idx_i != '0) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = (idx_i == '0) ? {DEVICE_ID, VENDOR_ID} : mem_q[idx_i];

  assert_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && idx_i != '0 |=> mem_q[$past(idx_i)] == $past(wdata_i));
endmodule

// File: rtl/pci_hb_ctrl.sv
module pci_hb_ctrl (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  pci_hb_pkg::ctrl_sel_e sel_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           par_o,
  output logic [31:0]           mbr_o,
  output logic [31:0]           iobr_o,
  output logic [31:0]           io_win_base_o
);
  import pci_hb_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_o  <= '0;
      mbr_o  <= '0;
      iobr_o <= '0;
    end else if (wr_i) begin
      unique case (sel_i)
        SEL_PAR:  par_o  <= wdata_i;
        SEL_MBR:  mbr_o  <= wdata_i & MBR_MASK;
        SEL_IOBR: iobr_o <= wdata_i & IOBR_MASK;
        default:  ;
      endcase
    end
  end

  assign io_win_base_o = iobr_o & WIN_MASK;

  assert_io_win_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && sel_i == SEL_IOBR |=> io_win_base_o == ($past(wdata_i) & WIN_MASK));
  assert_mbr_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && sel_i == SEL_MBR) |=> $stable(mbr_o));
endmodule

// File: rtl/pci_hb_irq_route.sv
module pci_hb_irq_route #(
  parameter int NUM_IRQ = 4,
  localparam int SW     = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_i,
  input  logic [7:0]         devfn_i,
  input  logic               level_i,
  output logic [NUM_IRQ-1:0] irq_o
);
  logic [4:0] slot;
  logic       in_range;

  assign slot     = devfn_i[7:3];
  assign in_range = int'(slot) < NUM_IRQ;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                irq_o <= '0;
    else if (upd_i && in_range) irq_o[slot[SW-1:0]] <= level_i;
  end

  assert_route_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && devfn_i[7:3] == 5'd2 |=> irq_o[2] == $past(level_i));
  assert_ignore_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && int'(devfn_i[7:3]) >= NUM_IRQ |=> $stable(irq_o));
endmodule

// File: rtl/pci_hb_regs.sv
module pci_hb_regs #(
  parameter int          ADDR_W    = 10,
  parameter int          NUM_IRQ   = 4,
  parameter logic [15:0] VENDOR_ID = 16'h1AB5,
  parameter logic [15:0] DEVICE_ID = 16'h0A11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [3:0]         be_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               ready_o,
  output logic               cfg_req_o,
  output logic               cfg_we_o,
  output logic [31:0]        cfg_addr_o,
  output logic [31:0]        cfg_wdata_o,
  input  logic [31:0]        cfg_rdata_i,
  input  logic               cfg_ack_i,
  output logic [31:0]        io_win_base_o,
  input  logic               irq_upd_i,
  input  logic [7:0]         irq_devfn_i,
  input  logic               irq_level_i,
  output logic [NUM_IRQ-1:0] irq_o
);
  import pci_hb_pkg::*;

  localparam int IW = $clog2(CFG_WORDS);
  localparam logic [ADDR_W-1:0] A_PAR   = ADDR_W'(OFF_PAR);
  localparam logic [ADDR_W-1:0] A_MBR   = ADDR_W'(OFF_MBR);
  localparam logic [ADDR_W-1:0] A_IOBR  = ADDR_W'(OFF_IOBR);
  localparam logic [ADDR_W-1:0] A_DPORT = ADDR_W'(OFF_DPORT);

  logic        full, hit_cfg, hit_dport, busy_q, acc;
  logic [31:0] cfg_rd, par, mbr, iobr;
  ctrl_sel_e   sel;

  assign full      = (be_i == 4'hF) && (addr_i[1:0] == 2'b00);
  assign hit_cfg   = full && (addr_i[ADDR_W-1:IW+2] == '0);
  assign hit_dport = full && (addr_i == A_DPORT);

  always_comb begin
    sel = SEL_NONE;
    if (full) begin
      unique case (addr_i)
        A_PAR:   sel = SEL_PAR;
        A_MBR:   sel = SEL_MBR;
        A_IOBR:  sel = SEL_IOBR;
        default: sel = SEL_NONE;
      endcase
    end
  end

  // downstream cycle: launch, hold until ack
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          busy_q <= 1'b0;
    else if (busy_q && cfg_ack_i)         busy_q <= 1'b0;
    else if (!busy_q && req_i && hit_dport) busy_q <= 1'b1;
  end

  assign ready_o     = req_i && (hit_dport ? (busy_q && cfg_ack_i) : 1'b1);
  assign acc         = req_i && ready_o && we_i;
  assign cfg_req_o   = busy_q;
  assign cfg_we_o    = we_i;
  assign cfg_addr_o  = par;
  assign cfg_wdata_o = wdata_i;

  pci_hb_cfgspace #(.WORDS(CFG_WORDS), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)) u_cfg (
    .clk_i, .rst_ni,
    .wr_i   (acc && hit_cfg),
    .idx_i  (addr_i[IW+1:2]),
    .wdata_i,
    .rdata_o(cfg_rd)
  );

  pci_hb_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .wr_i   (acc),
    .sel_i  (sel),
    .wdata_i,
    .par_o  (par),
    .mbr_o  (mbr),
    .iobr_o (iobr),
    .io_win_base_o
  );

  pci_hb_irq_route #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk_i, .rst_ni,
    .upd_i  (irq_upd_i),
    .devfn_i(irq_devfn_i),
    .level_i(irq_level_i),
    .irq_o
  );

  always_comb begin
    rdata_o = '0;
    if (hit_cfg)        rdata_o = cfg_rd;
    else if (hit_dport) rdata_o = cfg_rdata_i;
    else begin
      unique case (sel)
        SEL_PAR:  rdata_o = par;
        SEL_MBR:  rdata_o = mbr;
        SEL_IOBR: rdata_o = iobr;
        default:  rdata_o = '0;
      endcase
    end
  end

  assert_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && hit_dport && !(busy_q && cfg_ack_i) |-> !ready_o);
  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && !cfg_ack_i |=> cfg_req_o && $stable(cfg_addr_o));
  assert_partial_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_req_o && req_i && be_i != 4'hF |=> !cfg_req_o);
  assert_launch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_req_o && req_i && hit_dport |=> cfg_req_o);
endmodule

// File: tb/tb_pci_hb_regs.sv
`timescale 1ns/1ps
module tb_pci_hb_regs;
  localparam logic [31:0] ID = {16'h0A11, 16'h1AB5};

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        req = 0, we = 0, cfg_ack = 0, upd = 0, lvl = 0;
  logic [9:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wd = '0, cfg_rdata = '0;
  logic [7:0]  devfn = '0;
  logic [31:0] rdata, cfg_addr, cfg_wdata, io_win;
  logic        ready, cfg_req, cfg_we;
  logic [3:0]  irq;

  pci_hb_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .be_i(be),
    .wdata_i(wd), .rdata_o(rdata), .ready_o(ready), .cfg_req_o(cfg_req),
    .cfg_we_o(cfg_we), .cfg_addr_o(cfg_addr), .cfg_wdata_o(cfg_wdata),
    .cfg_rdata_i(cfg_rdata), .cfg_ack_i(cfg_ack), .io_win_base_o(io_win),
    .irq_upd_i(upd), .irq_devfn_i(devfn), .irq_level_i(lvl), .irq_o(irq)
  );

  int total = 0, failed = 0;
  int dly = 0, cnt = 0, n_launch = 0;
  logic        last_we;
  logic [31:0] last_addr, last_wd;

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  // downstream target model
  always @(negedge clk) begin
    if (cfg_req && !cfg_ack) begin
      if (cnt == dly) begin
        cfg_ack = 1; cnt = 0; n_launch++;
        last_we = cfg_we; last_addr = cfg_addr; last_wd = cfg_wdata;
        cfg_rdata = cfg_addr ^ 32'h5A5A_0000;
      end else cnt++;
    end else cfg_ack = 0;
  end

  task automatic bus(input logic w, input logic [9:0] a, input logic [31:0] d,
                     input logic [3:0] b, output logic [31:0] rd, output int waits);
    @(negedge clk);
    req = 1; we = w; addr = a; wd = d; be = b; waits = 0;
    forever begin
      #1;
      if (ready) break;
      waits++;
      @(negedge clk);
    end
    rd = rdata;
    @(posedge clk); #1;
    req = 0;
  endtask

  task automatic rd32(input logic [9:0] a, output logic [31:0] rd);
    int w;
    bus(1'b0, a, '0, 4'hF, rd, w);
  endtask

  task automatic wr32(input logic [9:0] a, input logic [31:0] d);
    logic [31:0] r; int w;
    bus(1'b1, a, d, 4'hF, r, w);
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'h1357_9BDF ^ (32'(i) * 32'h0101_0101);
  endfunction

  function automatic bit mapped(input int off);
    return off < 'h100 || off == 'h1C0 || off == 'h1C4 || off == 'h1C8 || off == 'h220;
  endfunction

  logic [31:0] exp_cfg [64];
  logic [31:0] exp_par, exp_mbr, exp_iobr;

  task automatic check_all(input string tag);
    logic [31:0] r;
    for (int i = 0; i < 64; i++) begin
      rd32(10'(i * 4), r);
      chk(tag, r, exp_cfg[i]);
    end
    rd32(10'h1C0, r); chk(tag, r, exp_par);
    rd32(10'h1C4, r); chk(tag, r, exp_mbr);
    rd32(10'h1C8, r); chk(tag, r, exp_iobr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    logic [31:0] r, p;
    logic [3:0]  eirq;
    int w, nl;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R3 / R12 reset state
    for (int i = 0; i < 64; i++) exp_cfg[i] = '0;
    exp_cfg[0] = ID; exp_cfg[1] = 32'h0290_0080;
    exp_par = '0; exp_mbr = '0; exp_iobr = '0;
    #1;
    chk("R12 io_win reset", io_win, '0);
    chk("R12 irq reset", {28'b0, irq}, '0);
    check_all("R3/R12 reset");

    // R2 / R4 sweep writes over local words
    for (int i = 0; i < 64; i++) begin
      wr32(10'(i * 4), pat(i));
      if (i != 0) exp_cfg[i] = pat(i);
    end
    check_all("R2/R4 cfg sweep");

    // R5 / R6 / R7 masks
    foreach (exp_cfg[k]) if (k == 0) ;
    for (int j = 0; j < 4; j++) begin
      p = (j == 0) ? 32'hFFFF_FFFF : (j == 1) ? 32'h1234_5678 :
          (j == 2) ? 32'h00FF_FFFE : 32'hA5C3_9E17;
      wr32(10'h1C0, p); exp_par = p;
      wr32(10'h1C4, p); exp_mbr = p & 32'hFF00_0001;
      wr32(10'h1C8, p); exp_iobr = p & 32'hFFFC_0001;
      rd32(10'h1C0, r); chk("R5 par", r, exp_par);
      rd32(10'h1C4, r); chk("R6 mbr", r, exp_mbr);
      rd32(10'h1C8, r); chk("R7 iobr", r, exp_iobr);
      chk("R7 io_win", io_win, p & 32'hFFFC_0000);
    end

    // R10 unmapped sweep
    for (int off = 0; off < 1024; off += 4) begin
      if (!mapped(off)) begin
        rd32(10'(off), r); chk("R10 unmapped read", r, '0);
        wr32(10'(off), 32'hFFFF_FFFF);
      end
    end
    check_all("R10 after unmapped writes");
    chk("R10 no downstream", 32'(n_launch), 0);

    // R1 partial accesses
    bus(1'b1, 10'h014, 32'hDEAD_BEEF, 4'h3, r, w);
    chk("R1 partial write ready", 32'(w), 0);
    bus(1'b0, 10'h014, '0, 4'h7, r, w);
    chk("R1 partial read zero", r, '0);
    bus(1'b1, 10'h1C0, 32'h0, 4'hE, r, w);
    bus(1'b1, 10'h220, 32'h0, 4'h1, r, w);
    chk("R1 partial dport ready", 32'(w), 0);
    repeat (2) @(negedge clk);
    chk("R1 partial dport no launch", 32'(n_launch), 0);
    check_all("R1 state unchanged");

    // R8 data port write, several delays
    for (int d = 0; d < 4; d++) begin
      dly = d * 3;
      p = 32'h8000_1000 + 32'(d * 8);
      wr32(10'h1C0, p); exp_par = p;
      nl = n_launch;
      bus(1'b1, 10'h220, 32'hCAFE_0000 + 32'(d), 4'hF, r, w);
      chk("R8 stall cycles", 32'(w), 32'(dly + 1));
      chk("R8 we", {31'b0, last_we}, 1);
      chk("R8 addr", last_addr, p);
      chk("R8 wdata", last_wd, 32'hCAFE_0000 + 32'(d));
      chk("R8 one launch", 32'(n_launch - nl), 1);
    end

    // R9 data port read
    for (int d = 0; d < 4; d++) begin
      dly = (d == 3) ? 7 : d;
      p = 32'h0001_0800 + 32'(d * 32'h100);
      wr32(10'h1C0, p); exp_par = p;
      bus(1'b0, 10'h220, '0, 4'hF, r, w);
      chk("R9 read data", r, p ^ 32'h5A5A_0000);
      chk("R9 we low", {31'b0, last_we}, 0);
      chk("R9 stall cycles", 32'(w), 32'(dly + 1));
    end
    repeat (2) @(negedge clk); #1;
    chk("R8 req released", {31'b0, cfg_req}, 0);

    // R11 interrupt routing sweep
    eirq = '0;
    for (int f = 0; f < 256; f++) begin
      @(negedge clk);
      upd = 1; devfn = 8'(f); lvl = f[0] ^ f[5] ^ f[1];
      if ((f >> 3) < 4) eirq[f >> 3] = lvl;
      @(negedge clk);
      upd = 0;
      #1;
      chk("R11 irq route", {28'b0, irq}, {28'b0, eirq});
    end

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule